// File: doc/BRIEF.md
# Auxiliary Compression State Tracker

This block follows, for one slice of a compressed surface, how the main surface data relates to its side-band compression data. It holds one of seven states and moves between them on draw events and explicit maintenance operations. The output tells the surrounding control logic whether the main surface can be read directly and whether the side-band data can be trusted. It also tells that logic when a requested event has no defined meaning in the current state.

A scheme-select input picks one of three rule sets. The general rule set uses the full graph. The lossless-colour rule set has no separate Resolved stop. The clear-only rule set uses only three of the states. A quirk input models hardware in which ordinary compressed draws can also fast-clear blocks. At most one event is accepted per clock. All outputs are registered and reflect the event taken at the previous edge.

Top module: `aux_trk_top`

## Requirements
- R1: State codes are Clear=0, Partial Clear=1, Compressed-with-Clear=2, Compressed-without-Clear=3, Resolved=4, Pass-through=5 and Aux Invalid=6. After a synchronous active-high reset, state_o is 6, main_ok_o is 0, aux_ok_o is 0 and bad_ev_o is 0.
- R2: Event codes are draw-with-aux=0, draw-clear-only=1, draw-without-aux=2, fast-clear=3, partial-fast-clear=4, partial-resolve=5, full-resolve=6 and ambiguate=7. A fast-clear event moves any state to Clear (0) under every scheme.
- R3: From Clear, draw-with-aux leads to 2 and draw-clear-only leads to 1. From Partial Clear, draw-clear-only stays in 1.
- R4: Partial-resolve takes 2 to 3. Under the general scheme, full-resolve takes 0, 1, 2 or 3 to Resolved (4).
- R5: Partial-fast-clear takes 3 to 2 and takes 5 to 1.
- R6: From Resolved, draw-with-aux leads to 3, draw-without-aux leads to 6 and ambiguate leads to 5.
- R7: Ambiguate takes 6 to 5. Draw-without-aux leaves both 6 and 5 unchanged. Draw-with-aux takes 5 to 3.
- R8: Scheme codes are general=0, lossless-colour=1, clear-only=2 (3 behaves as general). Under scheme 1, full-resolve goes directly to 5.
- R9: Under scheme 2, in states 0, 1 and 5, only the following events are legal: fast-clear; draw-clear-only (0 to 1, 1 to 1, 5 to 5); full-resolve (0 or 1 to 5); partial-fast-clear (5 to 1); and draw-without-aux (5 to 5). Every other event in those states is illegal.
- R10: With quirk_en=1, draw-with-aux from 4 or from 3 leads to 2 instead of 3.
- R11: main_ok_o is 1 only in states 4 and 5. aux_ok_o is 0 only in state 6.
- R12: An event that is not defined for the current state leaves the state unchanged and sets bad_ev_o for exactly one cycle. With ev_valid low, the state holds and bad_ev_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_code | input | 3 | Event code (R2) |
| scheme | input | 2 | Rule-set select (R8) |
| quirk_en | input | 1 | Draw side-effect fast-clear enable |
| state_o | output | 3 | Current state code (R1) |
| main_ok_o | output | 1 | Main surface holds valid data |
| aux_ok_o | output | 1 | Side-band data is valid |
| bad_ev_o | output | 1 | Previous event was illegal |

## Verification
The bench walks every edge of the general graph and checks both the state and the two validity flags after each step. A tracker that computes its flags from the old state would report them one step late, and this walk would show it. The lossless full resolve is checked to land in Pass-through and not Resolved. In the clear-only scheme, a compressed draw is sent and must be refused, because a permissive table would wrongly move into a compressed state. The quirk is exercised with the input both on and off from Resolved and from Compressed-without-Clear. An illegal event is followed by an idle cycle to show that the flag clears and the state is not disturbed.

// File: rtl/aux_trk_pkg.sv
package aux_trk_pkg;
  localparam int ST_W = 3;
  localparam int EV_W = 3;
  localparam int SC_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_CLEAR    = 3'd0,
    ST_PCLEAR   = 3'd1,
    ST_CMP_CLR  = 3'd2,
    ST_CMP_RAW  = 3'd3,
    ST_RESOLVED = 3'd4,
    ST_PASS     = 3'd5,
    ST_AUX_INV  = 3'd6,
    ST_SPARE    = 3'd7
  } trk_state_t;

  typedef enum logic [EV_W-1:0] {
    EV_DRAW_AUX   = 3'd0,
    EV_DRAW_CLR   = 3'd1,
    EV_DRAW_NOAUX = 3'd2,
    EV_FAST_CLR   = 3'd3,
    EV_PFAST_CLR  = 3'd4,
    EV_PART_RES   = 3'd5,
    EV_FULL_RES   = 3'd6,
    EV_AMBIG      = 3'd7
  } trk_event_t;

  localparam logic [SC_W-1:0] SC_GENERAL  = 2'd0;
  localparam logic [SC_W-1:0] SC_LOSSLESS = 2'd1;
  localparam logic [SC_W-1:0] SC_CLR_ONLY = 2'd2;
endpackage

// File: rtl/aux_trk_next.sv
module aux_trk_next
  import aux_trk_pkg::*;
(
  input  trk_state_t           cur,
  input  logic                 ev_valid,
  input  trk_event_t           ev,
  input  logic [SC_W-1:0]      scheme,
  input  logic                 quirk_en,
  output trk_state_t           nxt,
  output logic                 bad
);
  logic       clr_only_mode;
  logic       lossless_mode;
  trk_state_t res_tgt;
  trk_state_t aux_draw_tgt;
  trk_state_t cand;
  logic       undef;

  assign clr_only_mode = (scheme == SC_CLR_ONLY);
  assign lossless_mode = (scheme == SC_LOSSLESS);
  assign res_tgt       = lossless_mode ? ST_PASS : ST_RESOLVED;
  assign aux_draw_tgt  = quirk_en ? ST_CMP_CLR : ST_CMP_RAW;

  always_comb begin
    cand  = cur;
    undef = 1'b0;
    if (ev == EV_FAST_CLR) begin
      cand = ST_CLEAR;
    end else if (clr_only_mode &&
                 (cur == ST_CLEAR || cur == ST_PCLEAR || cur == ST_PASS)) begin
      case (ev)
        EV_DRAW_CLR:   cand = (cur == ST_PASS) ? ST_PASS : ST_PCLEAR;
        EV_FULL_RES:   if (cur != ST_PASS) cand = ST_PASS; else undef = 1'b1;
        EV_PFAST_CLR:  if (cur == ST_PASS) cand = ST_PCLEAR; else undef = 1'b1;
        EV_DRAW_NOAUX: if (cur != ST_PASS) undef = 1'b1;
        default:       undef = 1'b1;
      endcase
    end else begin
      case (cur)
        ST_CLEAR: case (ev)
          EV_DRAW_AUX: cand = ST_CMP_CLR;
          EV_DRAW_CLR: cand = ST_PCLEAR;
          EV_FULL_RES: cand = res_tgt;
          default:     undef = 1'b1;
        endcase
        ST_PCLEAR: case (ev)
          EV_DRAW_CLR: cand = ST_PCLEAR;
          EV_FULL_RES: cand = res_tgt;
          default:     undef = 1'b1;
        endcase
        ST_CMP_CLR: case (ev)
          EV_DRAW_AUX: cand = ST_CMP_CLR;
          EV_PART_RES: cand = ST_CMP_RAW;
          EV_FULL_RES: cand = res_tgt;
          default:     undef = 1'b1;
        endcase
        ST_CMP_RAW: case (ev)
          EV_DRAW_AUX:  cand = aux_draw_tgt;
          EV_PFAST_CLR: cand = ST_CMP_CLR;
          EV_FULL_RES:  cand = res_tgt;
          default:      undef = 1'b1;
        endcase
        ST_RESOLVED: case (ev)
          EV_DRAW_AUX:   cand = aux_draw_tgt;
          EV_DRAW_NOAUX: cand = ST_AUX_INV;
          EV_AMBIG:      cand = ST_PASS;
          default:       undef = 1'b1;
        endcase
        ST_PASS: case (ev)
          EV_DRAW_AUX:   cand = ST_CMP_RAW;
          EV_DRAW_CLR:   cand = ST_PASS;
          EV_DRAW_NOAUX: cand = ST_PASS;
          EV_PFAST_CLR:  cand = ST_PCLEAR;
          default:       undef = 1'b1;
        endcase
        ST_AUX_INV: case (ev)
          EV_DRAW_NOAUX: cand = ST_AUX_INV;
          EV_AMBIG:      cand = ST_PASS;
          default:       undef = 1'b1;
        endcase
        default: undef = 1'b1;
      endcase
    end
  end

  assign bad = ev_valid && undef;
  assign nxt = (ev_valid && !undef) ? cand : cur;
endmodule

// File: rtl/aux_trk_flags.sv
module aux_trk_flags
  import aux_trk_pkg::*;
(
  input  trk_state_t st,
  output logic       main_ok,
  output logic       aux_ok
);
  assign main_ok = (st == ST_RESOLVED) || (st == ST_PASS);
  assign aux_ok  = (st != ST_AUX_INV);
endmodule

// File: rtl/aux_trk_top.sv
module aux_trk_top
  import aux_trk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_valid,
  input  logic [EV_W-1:0] ev_code,
  input  logic [SC_W-1:0] scheme,
  input  logic            quirk_en,
  output logic [ST_W-1:0] state_o,
  output logic            main_ok_o,
  output logic            aux_ok_o,
  output logic            bad_ev_o
);
  trk_state_t state_q;
  trk_state_t state_d;
  logic       bad_d;
  logic       main_d;
  logic       aux_d;

  aux_trk_next u_next (
    .cur      (state_q),
    .ev_valid (ev_valid),
    .ev       (trk_event_t'(ev_code)),
    .scheme   (scheme),
    .quirk_en (quirk_en),
    .nxt      (state_d),
    .bad      (bad_d)
  );

  aux_trk_flags u_flags (
    .st      (state_d),
    .main_ok (main_d),
    .aux_ok  (aux_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_AUX_INV;
      main_ok_o <= 1'b0;
      aux_ok_o  <= 1'b0;
      bad_ev_o  <= 1'b0;
    end else begin
      state_q   <= state_d;
      main_ok_o <= main_d;
      aux_ok_o  <= aux_d;
      bad_ev_o  <= bad_d;
    end
  end

  assign state_o = state_q;

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> ($stable(state_o) && !bad_ev_o));

  p_bad_keeps_state_r12: assert property (@(posedge clk) disable iff (rst)
    ev_valid && bad_d |=> ($stable(state_o) && bad_ev_o));

  p_fast_clear_r2: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_code == EV_FAST_CLR |=> (state_o == ST_CLEAR && !bad_ev_o));

  p_main_implies_aux_r11: assert property (@(posedge clk) disable iff (rst)
    main_ok_o |-> aux_ok_o);

  p_aux_bad_only_inv_r11: assert property (@(posedge clk) disable iff (rst)
    !aux_ok_o |-> (state_o == ST_AUX_INV));

  p_clr_only_resolve_r9: assert property (@(posedge clk) disable iff (rst)
    ev_valid && scheme == SC_CLR_ONLY && ev_code == EV_FULL_RES &&
    (state_q == ST_CLEAR || state_q == ST_PCLEAR) |=> state_o == ST_PASS);

  p_lossless_resolve_r8: assert property (@(posedge clk) disable iff (rst)
    ev_valid && scheme == SC_LOSSLESS && ev_code == EV_FULL_RES &&
    state_q == ST_CMP_CLR |=> state_o == ST_PASS);
endmodule

// File: tb/test_aux_trk_top.sv
module test_aux_trk_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       ev_valid;
  logic [2:0] ev_code;
  logic [1:0] scheme;
  logic       quirk_en;
  logic [2:0] state_o;
  logic       main_ok_o;
  logic       aux_ok_o;
  logic       bad_ev_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  aux_trk_top i_aux_trk_top (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
    .scheme(scheme), .quirk_en(quirk_en), .state_o(state_o),
    .main_ok_o(main_ok_o), .aux_ok_o(aux_ok_o), .bad_ev_o(bad_ev_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int exp_st, input bit exp_bad);
    bit em = (exp_st == 4 || exp_st == 5);
    bit ea = (exp_st != 6);
    total++;
    if (state_o != exp_st[2:0]) begin
      bad++; $display("FAIL %s state act=%0d exp=%0d", req, state_o, exp_st);
    end
    total++;
    if (bad_ev_o != exp_bad) begin
      bad++; $display("FAIL %s illegal act=%0b exp=%0b", req, bad_ev_o, exp_bad);
    end
    total++;
    if (main_ok_o != em || aux_ok_o != ea) begin
      bad++; $display("FAIL R11 (%s) flags act=%0b%0b exp=%0b%0b", req,
                      main_ok_o, aux_ok_o, em, ea);
    end
  endtask

  task automatic step(input int code, input string req, input int exp_st, input bit exp_bad);
    @(negedge clk);
    ev_valid = 1'b1; ev_code = code[2:0];
    @(posedge clk); #1;
    ev_valid = 1'b0;
    check(req, exp_st, exp_bad);
  endtask

  task automatic idle(input string req, input int exp_st);
    @(negedge clk); ev_valid = 1'b0;
    @(posedge clk); #1;
    check(req, exp_st, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1; ev_valid = 1'b0; ev_code = 3'd0; scheme = 2'd0; quirk_en = 1'b0;
    repeat (3) @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    check("R1", 6, 1'b0);
  endtask

  task automatic t_general;
    scheme = 2'd0; quirk_en = 1'b0;
    step(2, "R7", 6, 0);
    step(7, "R7", 5, 0);
    step(2, "R7", 5, 0);
    step(0, "R7", 3, 0);
    step(4, "R5", 2, 0);
    step(5, "R4", 3, 0);
    step(6, "R4", 4, 0);
    step(7, "R6", 5, 0);
    step(4, "R5", 1, 0);
    step(1, "R3", 1, 0);
    step(6, "R4", 4, 0);
    step(0, "R6", 3, 0);
    step(3, "R2", 0, 0);
    step(0, "R3", 2, 0);
    step(3, "R2", 0, 0);
    step(1, "R3", 1, 0);
    step(6, "R4", 4, 0);
    step(2, "R6", 6, 0);
  endtask

  task automatic t_illegal;
    step(0, "R12", 6, 1);
    idle("R12", 6);
    step(5, "R12", 6, 1);
    step(3, "R2", 0, 0);
  endtask

  task automatic t_lossless;
    scheme = 2'd1;
    step(0, "R8", 2, 0);
    step(6, "R8", 5, 0);
    step(0, "R8", 3, 0);
    step(6, "R8", 5, 0);
  endtask

  task automatic t_clr_only;
    scheme = 2'd2;
    step(3, "R9", 0, 0);
    step(0, "R9", 0, 1);
    step(1, "R9", 1, 0);
    step(7, "R9", 1, 1);
    step(6, "R9", 5, 0);
    step(0, "R9", 5, 1);
    step(1, "R9", 5, 0);
    step(4, "R9", 1, 0);
    step(1, "R9", 1, 0);
  endtask

  task automatic t_quirk;
    scheme = 2'd0; quirk_en = 1'b1;
    step(3, "R10", 0, 0);
    step(6, "R10", 4, 0);
    step(0, "R10", 2, 0);
    step(5, "R10", 3, 0);
    step(0, "R10", 2, 0);
    quirk_en = 1'b0;
    step(5, "R10", 3, 0);
    step(0, "R10", 3, 0);
  endtask

  initial begin
    t_reset();
    t_general();
    t_illegal();
    t_lossless();
    t_clr_only();
    t_quirk();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule